// File: doc/BRIEF.md
# Signaling Change Detector with Debounce

This block watches a 6-bit signaling field that arrives once per frame for each of many channels on a time-slot serial interface. Each channel occupies a pair of slots. The odd slot of the pair holds the signaling bits in its upper six positions, and two handshake bits sit below them. The frame framer hands the block each received byte together with its slot index. It also gives a strobe at every frame start.

Only every N-th frame is sampled, and a period input sets N. For each channel the block keeps the last sampled value and the accepted (stable) value. A new value is accepted only when two consecutive samples agree and that value differs from the stable one. An accepted change updates the stable value and queues the channel's odd slot index in a 16-entry FIFO. The interrupt line stays high while that FIFO holds entries. The host reads the FIFO and can read back the stable value of any channel. A sticky flag records changes that were lost because the FIFO was full.

Top module: `sigchg_detect`

## Requirements
- R1: After reset every channel's stable value reads 6'h3F, the FIFO is empty, `irq` is low and `ovf` is low.
- R2: Only slots with an odd index are sampled. The channel number is `slot_idx[5:1]` and the sample is `slot_data[7:2]`. Even slots and `slot_data[1:0]` have no effect.
- R3: When a sample differs from the channel's last sample, it replaces the last sample and nothing is accepted.
- R4: When a sample equals the channel's last sample and differs from its stable value, it becomes the stable value and the odd slot index is pushed into the FIFO. Both results are visible after the clock edge that ends the slot cycle.
- R5: The block keeps a frame counter that is 0 after reset. On each `frame_start` the frame that follows is a sampling frame if the counter is 0. The counter then resets to 0 if it is greater than or equal to `period`, and otherwise it increments. Slots in frames that are not sampling frames have no effect. `period`=P therefore samples every P+1 frames, and the first frame after reset is sampled.
- R6: The FIFO holds 16 entries and returns them in push order. `fifo_data` always shows the oldest entry. A `fifo_pop` while the FIFO is empty is ignored.
- R7: A change accepted while the FIFO is full, and not popped in the same cycle, still updates the stable value but is not queued. It sets `ovf`, which stays set until `ovf_clr` is pulsed. If a drop and a clear occur in the same cycle, the set takes priority.
- R8: `irq` is high exactly while the FIFO is non-empty. It falls after the edge that pops the last entry.
- R9: `rd_stable` shows the stable value of channel `rd_ch` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at each frame start |
| period | input | 8 | Sampling period in frames minus one |
| slot_valid | input | 1 | Received slot byte valid |
| slot_idx | input | 6 | Time slot index of the byte |
| slot_data | input | 8 | Received slot byte |
| rd_ch | input | 5 | Channel selected for stable readback |
| rd_stable | output | 6 | Stable value of channel `rd_ch` |
| fifo_pop | input | 1 | Remove the oldest FIFO entry |
| fifo_data | output | 6 | Oldest queued slot index |
| fifo_empty | output | 1 | FIFO holds no entries |
| ovf_clr | input | 1 | Clear the overflow flag |
| ovf | output | 1 | Sticky flag for a change dropped because the FIFO was full |
| irq | output | 1 | Change interrupt |

## Verification
A slot byte driven in one cycle updates the stable value, the FIFO and `irq` at the next rising edge. `frame_start` moves the sampling decision at the same edge, so a slot driven in the cycle after the strobe already belongs to the new frame. A pop or an `ovf_clr` takes effect at the edge that ends its cycle, while `rd_stable` follows `rd_ch` with no clock. The bench drives its inputs on falling edges and checks one falling edge later, which is half a cycle after the edge that carries the effect. For readback it waits a short delay after it changes `rd_ch`.

// File: rtl/sigchg_pkg.sv
package sigchg_pkg;
    localparam int SIG_W  = 6;
    localparam int BYTE_W = 8;
    typedef logic [SIG_W-1:0] sig_t;
endpackage

// File: rtl/sigchg_pacer.sv
module sigchg_pacer #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [PER_W-1:0] period,
    output logic             sample_act
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             act;
    } pace_t;

    pace_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.act = (st_q.cnt == '0);
            st_d.cnt = (st_q.cnt >= period) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_act = st_q.act;

    // R5: the sampling decision only moves at a frame strobe
    assert_act_at_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(sample_act));
endmodule

// File: rtl/sigchg_chan_store.sv
module sigchg_chan_store
    import sigchg_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int SLOT_W = $clog2(2*NUM_CH),
    localparam int CH_W   = SLOT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_act,
    input  logic              slot_valid,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [BYTE_W-1:0] slot_data,
    input  logic [CH_W-1:0]   rd_ch,
    output sig_t              rd_stable,
    output logic              accept,
    output logic [SLOT_W-1:0] accept_slot
);
    typedef struct packed {
        logic [NUM_CH-1:0][SIG_W-1:0] act;
        logic [NUM_CH-1:0][SIG_W-1:0] stb;
    } store_t;

    store_t          st_d, st_q;
    logic [CH_W-1:0] ch;
    sig_t            smp;
    logic            hit;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        ch     = slot_idx[SLOT_W-1:1];
        smp    = slot_data[BYTE_W-1:BYTE_W-SIG_W];
        hit    = slot_valid && sample_act && slot_idx[0];
        if (hit) begin
            if (smp != st_q.act[ch]) begin
                st_d.act[ch] = smp;
            end else if (smp != st_q.stb[ch]) begin
                st_d.stb[ch] = smp;
                accept       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign rd_stable   = st_q.stb[rd_ch];
    assign accept_slot = slot_idx;

    // R4: a stable value never moves without an accepted change
    assert_stable_only_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(st_q.stb));
    // R5: slots outside a sampling frame leave all channel state untouched
    assert_idle_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_act |=> $stable(st_q));
endmodule

// File: rtl/sigchg_fifo.sv
module sigchg_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 6,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         ovf_clr,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         ovf
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  full, do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == DEPTH_C);
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (!full || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == LAST_C) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST_C) ? '0 : st_q.rp + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        if (ovf_clr)            st_d.ovf = 1'b0;
        if (push && !do_push)   st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign ovf   = st_q.ovf;

    // R6: occupancy never exceeds the depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DEPTH_C);
    // R6: popping an empty FIFO with nothing arriving keeps it empty
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
    // R7: a push into a full FIFO without a pop raises the sticky flag
    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> ovf);
    // R7: the flag only falls when cleared
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/sigchg_detect.sv
module sigchg_detect
    import sigchg_pkg::*;
#(
    parameter int NUM_CH     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int PER_W      = 8,
    localparam int SLOT_W    = $clog2(2*NUM_CH),
    localparam int CH_W      = SLOT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [PER_W-1:0]  period,
    input  logic              slot_valid,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [7:0]        slot_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [5:0]        rd_stable,
    input  logic              fifo_pop,
    output logic [SLOT_W-1:0] fifo_data,
    output logic              fifo_empty,
    input  logic              ovf_clr,
    output logic              ovf,
    output logic              irq
);
    logic              sample_act;
    logic              accept;
    logic [SLOT_W-1:0] accept_slot;

    sigchg_pacer #(.PER_W(PER_W)) u_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .period      (period),
        .sample_act  (sample_act)
    );

    sigchg_chan_store #(.NUM_CH(NUM_CH)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_act  (sample_act),
        .slot_valid  (slot_valid),
        .slot_idx    (slot_idx),
        .slot_data   (slot_data),
        .rd_ch       (rd_ch),
        .rd_stable   (rd_stable),
        .accept      (accept),
        .accept_slot (accept_slot)
    );

    sigchg_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (accept),
        .din     (accept_slot),
        .pop     (fifo_pop),
        .ovf_clr (ovf_clr),
        .dout    (fifo_data),
        .empty   (fifo_empty),
        .ovf     (ovf)
    );

    assign irq = !fifo_empty;

    // R8: the interrupt only rises after an accepted change
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(accept));
    // R4: a change queued into a FIFO that was empty always names an odd slot
    assert_odd_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fifo_empty) |=> fifo_data[0]);
endmodule

// File: tb/sigchg_detect_test.sv
module sigchg_detect_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] period = 8'd0;
    logic       slot_valid = 1'b0;
    logic [5:0] slot_idx = '0;
    logic [7:0] slot_data = '0;
    logic [4:0] rd_ch = '0;
    logic [5:0] rd_stable;
    logic       fifo_pop = 1'b0;
    logic [5:0] fifo_data;
    logic       fifo_empty;
    logic       ovf_clr = 1'b0;
    logic       ovf;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [5:0] ma [32];
    logic [5:0] ms [32];
    logic [5:0] mq [$];
    logic       movf;
    int         mcnt;
    bit         mact;

    sigchg_detect uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_frame();
        mact = (mcnt == 0);
        mcnt = (mcnt >= int'(period)) ? 0 : mcnt + 1;
    endtask

    task automatic model_slot(input logic [5:0] idx, input logic [7:0] d);
        int ch;
        logic [5:0] s;
        if (mact && idx[0]) begin
            ch = int'(idx[5:1]);
            s  = d[7:2];
            if (s != ma[ch]) ma[ch] = s;
            else if (s != ms[ch]) begin
                ms[ch] = s;
                if (mq.size() < 16) mq.push_back(idx);
                else movf = 1'b1;
            end
        end
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        model_frame();
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic slot(input logic [5:0] idx, input logic [7:0] d);
        slot_valid = 1'b1;
        slot_idx   = idx;
        slot_data  = d;
        model_slot(idx, d);
        @(negedge clk);
        slot_valid = 1'b0;
    endtask

    task automatic check_stable(input int ch, input string req);
        rd_ch = 5'(ch);
        #1;
        chk(rd_stable == ms[ch], req, rd_stable, ms[ch]);
    endtask

    task automatic drain(input string req);
        chk(irq == (mq.size() != 0), "R8 irq", irq, mq.size() != 0);
        while (mq.size() > 0) begin
            chk(!fifo_empty && fifo_data == mq[0], req, fifo_data, mq[0]);
            fifo_pop = 1'b1;
            @(negedge clk);
            fifo_pop = 1'b0;
            void'(mq.pop_front());
        end
        chk(fifo_empty && !irq, "R8 empty after drain", {fifo_empty, irq}, 2'b10);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 32; i++) begin ma[i] = 6'h3F; ms[i] = 6'h3F; end
        movf = 1'b0; mcnt = 0; mact = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and R9 readback
        for (int i = 0; i < 32; i++) check_stable(i, "R1 reset stable");
        chk(fifo_empty && !irq && !ovf, "R1 reset flags", {fifo_empty, irq, ovf}, 3'b100);

        // R4 two agreeing looks accept
        frame(); slot(6'd7, {6'h15, 2'b00});
        chk(fifo_empty, "R3 first look not accepted", fifo_empty, 1);
        frame(); slot(6'd7, {6'h15, 2'b11});
        chk(irq && !fifo_empty, "R4 change queued", irq, 1);
        check_stable(3, "R4 stable updated");
        drain("R4 slot address");

        // R3 glitch restarts the check
        frame(); slot(6'd7, {6'h20, 2'b00});
        frame(); slot(6'd7, {6'h15, 2'b00});
        frame(); slot(6'd7, {6'h15, 2'b00});
        chk(fifo_empty, "R3 glitch no change", fifo_empty, 1);
        check_stable(3, "R3 stable kept");

        // R2 even slots ignored, low bits ignored
        frame(); slot(6'd6, 8'h00);
        frame(); slot(6'd6, 8'h00);
        chk(fifo_empty, "R2 even slot ignored", fifo_empty, 1);
        check_stable(3, "R2 even slot stable kept");
        frame(); slot(6'd9, {6'h2A, 2'b01});
        frame(); slot(6'd9, {6'h2A, 2'b10});
        check_stable(4, "R2 low bits ignored");
        drain("R2 odd slot queued");

        // R5 sampling period: samples every third frame
        period = 8'd2;
        for (int f = 0; f < 9; f++) begin
            frame(); slot(6'd11, {6'(6'h30 + f/2), 2'b00});
            check_stable(5, "R5 period sampling");
            drain("R5 period queue");
        end
        period = 8'd0;
        while (mcnt != 0) frame();

        // R7 overflow: 32 changes, 16 kept
        for (int r = 0; r < 2; r++) begin
            frame();
            for (int c = 0; c < 32; c++) slot(6'(2*c+1), {6'h01, 2'b00});
        end
        chk(ovf == movf && ovf, "R7 ovf set", ovf, 1);
        check_stable(31, "R7 dropped change still stable");
        @(negedge clk);
        chk(ovf, "R7 ovf sticky", ovf, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; movf = 1'b0;
        chk(!ovf, "R7 ovf cleared", ovf, 0);
        drain("R6 fifo order");

        // R6 pop on empty ignored
        fifo_pop = 1'b1; @(negedge clk); fifo_pop = 1'b0;
        chk(fifo_empty && !irq, "R6 empty pop ignored", fifo_empty, 1);
        frame(); slot(6'd1, {6'h02, 2'b00});
        frame(); slot(6'd1, {6'h02, 2'b00});
        drain("R6 push after empty pop");

        // random traffic
        for (int f = 0; f < 300; f++) begin
            if (f % 40 == 0 && mcnt == 0) period = 8'($urandom % 3);
            frame();
            for (int c = 0; c < 12; c++) begin
                int unsigned r;
                logic [5:0] v;
                r = $urandom;
                case (r % 4)
                    0: v = 6'($urandom);
                    1: v = ms[c];
                    default: v = ma[c];
                endcase
                slot(6'(2*c + ((r % 7 == 0) ? 0 : 1)), {v, 2'($urandom)});
            end
            check_stable(int'($urandom % 12), "R4 random stable");
            drain("R4 random queue");
            chk(ovf == movf, "R7 random ovf", ovf, movf);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule